// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker takes a start address, fetches a chain of command blocks from system memory and hands their payload words, in order, to a downstream command framer. Every block begins with one header word. The top eight bits of that word hold the number of payload words. The low 24 bits hold the address of the following block. The payload words sit directly after the header. The walk stops at the first link whose bit 23 is set.

Memory is reached through a request/response read port. It carries one request at a time, addresses it by word, and accepts any response latency. A read is issued only while the framer is ready and no payload word is waiting to be taken. The payload leaves on a valid/ready handshake.

Two results come out of each walk: the number of blocks walked and a cost estimate. Each block adds five cycles plus its payload length to that estimate. A cyclic or runaway list is cut off after a parameterised number of blocks, and the walker then reports a loop error instead of normal completion.

Top module: `chain_walker`

## Requirements
- R1: After reset, busy, outValid, done, loopError and memReq are all low.
- R2: Header bits 31:24 give the payload word count and bits 23:0 give the next block address. The payload words are read from block address + 4 onward and are presented on outData in address order.
- R3: Only the low 24 bits of startAddr are used. A walk ends at the first current address whose bit 23 is set, including the start address. On that end, done is high for exactly one cycle with busy low. When the start address already has bit 23 set, done comes with no memory read.
- R4: memWordIdx is bits 20:2 of the address being read, so addresses alias modulo 2 MiB.
- R5: A block with a payload length of zero emits no words, and the walk goes on to its link.
- R6: At the end of a walk, nodeCount holds the number of headers read and cycleEst holds the sum over those blocks of 5 + length.
- R7: When NODE_LIMIT blocks have been walked and the next address has bit 23 clear, the walk stops. loopError is then high for one cycle, done stays low, and nodeCount equals NODE_LIMIT.
- R8: memReq is high only while outReady is high and outValid is low. It is never high in two consecutive cycles.
- R9: While outValid is high and outReady is low, outValid stays high and outData does not change.
- R10: A start pulse while busy is high is ignored. The walk in progress finishes with its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at startAddr (taken only when idle) |
| startAddr | input | 32 | Address of the first block |
| memReq | output | 1 | One-cycle read request |
| memWordIdx | output | ADDR_BITS-2 | Word index of the read |
| memValid | input | 1 | Read response valid |
| memData | input | 32 | Read response data |
| outValid | output | 1 | Payload word valid |
| outData | output | 32 | Payload word |
| outReady | input | 1 | Framer accepts the payload word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: the walk reached an end link |
| loopError | output | 1 | One-cycle pulse: the walk was cut off at the block limit |
| nodeCount | output | $clog2(NODE_LIMIT+1) | Blocks walked in the current or last walk |
| cycleEst | output | COST_W | Cost estimate of the current or last walk |

## Verification
The bench does not check any result against a fixed cycle number. The reason is that read latency and framer backpressure move every event in time. The walk's termination pulse appears one cycle after the walker examines an end link or a full block count. The bench polls on the falling edge until done or loopError is seen. After that it compares nodeCount and cycleEst, which hold their values once the walker is idle. Payload words are captured on every falling edge where outValid and outReady are both high. The captured words are then compared, in order, against a walk of the same memory image computed inside the bench. The bench also counts any request raised while outReady is low, and any request outside the low 4 KiB once an aliased link has been followed.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;

  localparam int WORD_W   = 32;
  localparam int LINK_W   = 24;
  localparam int END_BIT  = 23;
  localparam int LEN_W    = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_PAY_REQ,
    ST_PAY_WAIT,
    ST_PAY_OUT,
    ST_LINK
  } walkState_t;

  typedef struct packed {
    logic loadStart;
    logic loadHdr;
    logic loadOut;
    logic loadLink;
    logic selPayload;
  } walkStrobe_t;

  typedef struct packed {
    logic addrEnd;
    logic limitHit;
    logic lenZero;
    logic wordsLeft;
  } walkStatus_t;

endpackage

// File: rtl/chain_walker_ctrl.sv
module chain_walker_ctrl
  import chain_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memValid,
  input  logic        outReady,
  input  logic        outValid,
  input  walkStatus_t status,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        busy,
  output logic        done,
  output logic        loopError
);

  walkState_t state, nextState;
  logic finDone, finLoop;
  logic readOk;

  assign readOk = outReady && !outValid;

  always_comb begin
    nextState = state;
    strobe    = '0;
    memReq    = 1'b0;
    finDone   = 1'b0;
    finLoop   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadStart = 1'b1;
          nextState        = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.addrEnd) begin
          finDone   = 1'b1;
          nextState = ST_IDLE;
        end else if (status.limitHit) begin
          finLoop   = 1'b1;
          nextState = ST_IDLE;
        end else begin
          nextState = ST_HDR_REQ;
        end
      end
      ST_HDR_REQ: begin
        if (readOk) begin
          memReq    = 1'b1;
          nextState = ST_HDR_WAIT;
        end
      end
      ST_HDR_WAIT: begin
        if (memValid) begin
          strobe.loadHdr = 1'b1;
          nextState      = status.lenZero ? ST_LINK : ST_PAY_REQ;
        end
      end
      ST_PAY_REQ: begin
        strobe.selPayload = 1'b1;
        if (readOk) begin
          memReq    = 1'b1;
          nextState = ST_PAY_WAIT;
        end
      end
      ST_PAY_WAIT: begin
        strobe.selPayload = 1'b1;
        if (memValid) begin
          strobe.loadOut = 1'b1;
          nextState      = ST_PAY_OUT;
        end
      end
      ST_PAY_OUT: begin
        strobe.selPayload = 1'b1;
        if (outReady) begin
          nextState = status.wordsLeft ? ST_PAY_REQ : ST_LINK;
        end
      end
      ST_LINK: begin
        strobe.loadLink = 1'b1;
        nextState       = ST_CHECK;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      loopError <= 1'b0;
    end else begin
      state     <= nextState;
      done      <= finDone;
      loopError <= finLoop;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/chain_walker_dp.sv
module chain_walker_dp
  import chain_walker_pkg::*;
#(
  parameter int ADDR_BITS  = 21,
  parameter int NODE_LIMIT = 8192,
  parameter int COST_BASE  = 5,
  parameter int COST_W     = 32,
  localparam int IDX_W     = ADDR_BITS - 2,
  localparam int CNT_W     = $clog2(NODE_LIMIT + 1)
)(
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strobe,
  input  logic [WORD_W-1:0]   startAddr,
  input  logic [WORD_W-1:0]   memData,
  input  logic                outReady,
  output walkStatus_t         status,
  output logic [IDX_W-1:0]    memWordIdx,
  output logic                outValid,
  output logic [WORD_W-1:0]   outData,
  output logic [CNT_W-1:0]    nodeCount,
  output logic [COST_W-1:0]   cycleEst
);

  logic [LINK_W-1:0] curAddr;
  logic [LINK_W-1:0] nextAddr;
  logic [LINK_W-1:0] rdPtr;
  logic [LEN_W-1:0]  remaining;
  logic [LEN_W-1:0]  hdrLen;
  logic [LINK_W-1:0] hdrLink;
  logic [LINK_W-1:0] rdAddr;

  assign hdrLen  = memData[WORD_W-1 -: LEN_W];
  assign hdrLink = memData[LINK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      nextAddr  <= '0;
      rdPtr     <= '0;
      remaining <= '0;
      nodeCount <= '0;
      cycleEst  <= '0;
    end else begin
      if (strobe.loadStart) begin
        curAddr   <= startAddr[LINK_W-1:0];
        nodeCount <= '0;
        cycleEst  <= '0;
      end
      if (strobe.loadHdr) begin
        nextAddr  <= hdrLink;
        remaining <= hdrLen;
        rdPtr     <= curAddr + LINK_W'(4);
        nodeCount <= nodeCount + CNT_W'(1);
        cycleEst  <= cycleEst + COST_W'(COST_BASE) + COST_W'(hdrLen);
      end
      if (strobe.loadOut) begin
        rdPtr     <= rdPtr + LINK_W'(4);
        remaining <= remaining - LEN_W'(1);
      end
      if (strobe.loadLink) begin
        curAddr <= nextAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (strobe.loadOut) begin
      outValid <= 1'b1;
      outData  <= memData;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

  assign rdAddr     = strobe.selPayload ? rdPtr : curAddr;
  assign memWordIdx = rdAddr[ADDR_BITS-1:2];

  assign status.addrEnd   = curAddr[END_BIT];
  assign status.limitHit  = (nodeCount == CNT_W'(NODE_LIMIT));
  assign status.lenZero   = (hdrLen == '0);
  assign status.wordsLeft = (remaining != '0);

endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_walker_pkg::*;
#(
  parameter int ADDR_BITS  = 21,
  parameter int NODE_LIMIT = 8192,
  parameter int COST_BASE  = 5,
  parameter int COST_W     = 32,
  localparam int IDX_W     = ADDR_BITS - 2,
  localparam int CNT_W     = $clog2(NODE_LIMIT + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       startAddr,
  output logic              memReq,
  output logic [IDX_W-1:0]  memWordIdx,
  input  logic              memValid,
  input  logic [31:0]       memData,
  output logic              outValid,
  output logic [31:0]       outData,
  input  logic              outReady,
  output logic              busy,
  output logic              done,
  output logic              loopError,
  output logic [CNT_W-1:0]  nodeCount,
  output logic [COST_W-1:0] cycleEst
);

  walkStrobe_t strobe;
  walkStatus_t status;

  chain_walker_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memValid  (memValid),
    .outReady  (outReady),
    .outValid  (outValid),
    .status    (status),
    .strobe    (strobe),
    .memReq    (memReq),
    .busy      (busy),
    .done      (done),
    .loopError (loopError)
  );

  chain_walker_dp #(
    .ADDR_BITS  (ADDR_BITS),
    .NODE_LIMIT (NODE_LIMIT),
    .COST_BASE  (COST_BASE),
    .COST_W     (COST_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startAddr  (startAddr),
    .memData    (memData),
    .outReady   (outReady),
    .status     (status),
    .memWordIdx (memWordIdx),
    .outValid   (outValid),
    .outData    (outData),
    .nodeCount  (nodeCount),
    .cycleEst   (cycleEst)
  );

endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
  parameter int NODE_LIMIT = 8192,
  localparam int CNT_W     = $clog2(NODE_LIMIT + 1)
)(
  input logic             clk,
  input logic             rstN,
  input logic             memReq,
  input logic             outValid,
  input logic [31:0]      outData,
  input logic             outReady,
  input logic             busy,
  input logic             done,
  input logic             loopError,
  input logic [CNT_W-1:0] nodeCount
);

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (outReady && !outValid)); // R8

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R3

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(done && loopError)); // R7

  AST_LOOP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    loopError |-> (nodeCount == CNT_W'(NODE_LIMIT))); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    nodeCount <= CNT_W'(NODE_LIMIT)); // R7

endmodule

bind chain_walker chain_walker_chk #(.NODE_LIMIT(NODE_LIMIT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .outValid  (outValid),
  .outData   (outData),
  .outReady  (outReady),
  .busy      (busy),
  .done      (done),
  .loopError (loopError),
  .nodeCount (nodeCount)
);

// File: tb/test_chain_walker.sv
`timescale 1ns/1ps
module test_chain_walker;

  localparam int LIMIT = 16;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam int MAXW  = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] startAddr = '0;
  logic        memReq;
  logic [18:0] memWordIdx;
  logic        memValid;
  logic [31:0] memData;
  logic        outValid;
  logic [31:0] outData;
  logic        outReady = 1'b1;
  logic        busy, done, loopError;
  logic [CNT_W-1:0] nodeCount;
  logic [31:0] cycleEst;

  chain_walker #(.NODE_LIMIT(LIMIT)) i_chain_walker (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .memReq(memReq), .memWordIdx(memWordIdx), .memValid(memValid), .memData(memData),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .busy(busy), .done(done), .loopError(loopError),
    .nodeCount(nodeCount), .cycleEst(cycleEst)
  );

  always #2.5 clk = ~clk;

  logic [31:0] mem [1024];

  always_ff @(posedge clk) begin
    memValid <= memReq;
    memData  <= mem[memWordIdx[9:0]];
  end

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // backpressure pattern driver
  bit       bpMode = 0;
  logic [7:0] lfsr = 8'h5a;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = bpMode ? lfsr[0] : 1'b1;
  end

  // monitor
  logic [31:0] gotWords [MAXW];
  int  gotN = 0;
  int  reqCount = 0;
  int  reqNotReady = 0;
  int  reqHighIdx = 0;
  bit  seenDone = 0, seenLoop = 0;
  always @(negedge clk) begin
    if (outValid && outReady) begin
      if (gotN < MAXW) gotWords[gotN] = outData;
      gotN++;
    end
    if (memReq) begin
      reqCount++;
      if (!outReady) reqNotReady++;
      if (memWordIdx[18:10] != 0) reqHighIdx++;
    end
    if (done) seenDone = 1;
    if (loopError) seenLoop = 1;
  end

  // reference walk
  logic [31:0] expWords [MAXW];
  int  expN, expNodes, expCost;
  bit  expLoop;

  task automatic refWalk(input logic [31:0] sa);
    logic [23:0] a;
    logic [31:0] h;
    a = sa[23:0];
    expN = 0; expNodes = 0; expCost = 0; expLoop = 0;
    forever begin
      if (a[23]) break;
      if (expNodes == LIMIT) begin expLoop = 1; break; end
      h = mem[a[11:2]];
      expNodes++;
      expCost += 5 + int'(h[31:24]);
      for (int i = 0; i < int'(h[31:24]); i++) begin
        logic [23:0] pa;
        pa = a + 24'(4 * (i + 1));
        if (expN < MAXW) expWords[expN] = mem[pa[11:2]];
        expN++;
      end
      a = h[23:0];
    end
  endtask

  task automatic putNode(input logic [23:0] a, input int len, input logic [23:0] nxt, input logic [31:0] base);
    mem[a[11:2]] = {8'(len), nxt};
    for (int i = 0; i < len; i++) begin
      logic [23:0] pa;
      pa = a + 24'(4 * (i + 1));
      mem[pa[11:2]] = base + 32'(i);
    end
  endtask

  task automatic runWalk(input logic [31:0] sa, input bit intrude, input logic [31:0] otherAddr);
    @(posedge clk); #1;
    gotN = 0; reqCount = 0; reqNotReady = 0; reqHighIdx = 0;
    seenDone = 0; seenLoop = 0;
    start = 1; startAddr = sa;
    @(posedge clk); #1;
    start = 0;
    if (intrude) begin
      repeat (3) @(posedge clk);
      #1; start = 1; startAddr = otherAddr;
      @(posedge clk); #1; start = 0;
    end
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (seenDone || seenLoop) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(req, "word count", gotN, expN);
    for (int i = 0; i < expN && i < gotN && i < MAXW; i++)
      check(req, $sformatf("word %0d", i), gotWords[i], expWords[i]);
    check("R6", "nodeCount", nodeCount, expNodes);
    check("R6", "cycleEst", cycleEst, expCost);
    check(expLoop ? "R7" : "R3", "done seen", seenDone, !expLoop);
    check("R7", "loopError seen", seenLoop, expLoop);
    check("R8", "requests while not ready", reqNotReady, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "outValid", outValid, 0);
    check("R1", "done", done, 0);
    check("R1", "loopError", loopError, 0);
    check("R1", "memReq", memReq, 0);
  endtask

  task automatic testSingle();   // R2 single block
    refWalk(32'h0000_0010);
    check("R2", "reference cost", expCost, 8);
    runWalk(32'h0000_0010, 0, 0);
    compare("R2");
  endtask

  task automatic testZeroLenBackpressure(); // R5 with R9 backpressure
    bpMode = 1;
    refWalk(32'h0000_0100);
    check("R5", "reference cost", expCost, 21);
    runWalk(32'h0000_0100, 0, 0);
    compare("R5");
    bpMode = 0;
  endtask

  task automatic testEndAtStart(); // R3
    refWalk(32'h0080_0100);
    runWalk(32'h0080_0100, 0, 0);
    compare("R3");
    check("R3", "reads issued", reqCount, 0);
    check("R3", "busy after done", busy, 0);
  endtask

  task automatic testAlias(); // R4 and R3 masking
    refWalk(32'hFF00_0200);
    runWalk(32'hFF00_0200, 0, 0);
    compare("R4");
    check("R4", "requests above low 4KiB", reqHighIdx, 0);
  endtask

  task automatic testLoop(); // R7
    refWalk(32'h0000_0300);
    check("R7", "reference nodes", expNodes, LIMIT);
    runWalk(32'h0000_0300, 0, 0);
    compare("R7");
  endtask

  task automatic testBusyStart(); // R10
    refWalk(32'h0000_0010);
    runWalk(32'h0000_0010, 1, 32'h0000_0300);
    compare("R10");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    putNode(24'h000010, 3, 24'h800000, 32'hA000_0000);
    putNode(24'h000100, 2, 24'h000140, 32'hB000_0000);
    putNode(24'h000140, 0, 24'h000180, 32'h0);
    putNode(24'h000180, 4, 24'h9ABCDE, 32'hC000_0000);
    putNode(24'h000200, 1, 24'h200240, 32'hD000_0000);
    putNode(24'h000240, 2, 24'h800000, 32'hE000_0000);
    putNode(24'h000300, 1, 24'h000300, 32'hF000_0000);
    repeat (4) @(posedge clk);
    testReset();
    #1 rstN = 1;
    testSingle();
    testZeroLenBackpressure();
    testEndAtStart();
    testAlias();
    testLoop();
    testBusyStart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule